// File: doc/BRIEF.md
# Windowed Input Activity Monitor

This block tells whether one selected data input is toggling. A slow, unrelated monitor clock splits time into windows. At each rising edge of that clock the block reports on the window that has just closed, and it starts a fresh window at the same moment. A window counts as active only when the watched signal went both up and down inside it. The watched input is picked by a select code from the configuration store. A code that names no existing input turns the monitor off.

The watched line and the monitor clock are both brought into the system clock domain through two-flop synchronisers. Edges are then found on the synchronised samples. Both paths have the same depth, so an input change and a monitor-clock rise that arrive in the same system cycle line up. A small state machine tracks what the open window has seen:

- `MON_WAIT`: nothing seen yet.
- `MON_RISE`: only a rise seen.
- `MON_FALL`: only a fall seen.
- `MON_BOTH`: both a rise and a fall seen.

The transitions are:

- A rise moves `MON_WAIT` to `MON_RISE`.
- A fall moves `MON_WAIT` to `MON_FALL`.
- A fall moves `MON_RISE` to `MON_BOTH`.
- A rise moves `MON_FALL` to `MON_BOTH`.
- `MON_BOTH` stays put until the window ends.
- A window boundary takes any state back to `MON_WAIT` and then applies the edge of that same cycle.

At the boundary, the output register loads 1 if the state was `MON_BOTH` and 0 otherwise.

Top module: `activity_monitor`

## Requirements
- R1: `activity` changes only at a window boundary. With `mon_clk` raised just after a rising `clk` edge, the new result is visible after the third rising `clk` edge that follows. Between boundaries it holds.
- R2: A boundary clears the window state. A window with no edges reports 0, even when the window before it was active.
- R3: A window reports 1 only if it held at least one rise and at least one fall of the watched signal. Rises only, or falls only, report 0.
- R4: An edge of the watched signal that is synchronised in the same `clk` cycle as a monitor-clock rise belongs to the new window, not to the closing one.
- R5: With `mon_sel` below `N_IN`, the watched signal is `data_in[mon_sel]`. Toggles on any other input have no effect on `activity`.
- R6: With `mon_sel` at `N_IN` or above (for example 127, the disable code), the watched signal is held at 0. No window reports activity, whatever `data_in` does.
- R7: Synchronous reset (`rst` high) returns the state to `MON_WAIT` and drives `activity` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_clk | input | 1 | Monitor clock; each rising edge closes a window |
| mon_sel | input | SEL_W (7) | Monitor select code from the configuration store |
| data_in | input | N_IN (68) | Data inputs that can be watched |
| activity | output | 1 | Result for the last closed window |

## Verification
The bench goes after the window boundary. It flips the watched line in the very cycle the monitor clock rises. A design that gave that edge to the old window would report a half-seen window as active, and would leave the next window short of an edge. It runs windows with only rises and windows with only falls, which catch a design that ORs the two flags instead of ANDing them. It runs an empty window after an active one, which exposes a missing clear. Further tests toggle inputs that are not selected, and toggle every input under the disable code. A broken selector shows up there as false activity.

// File: rtl/amon_pkg.sv
package amon_pkg;
    typedef enum logic [1:0] {
        MON_WAIT = 2'd0,
        MON_RISE = 2'd1,
        MON_FALL = 2'd2,
        MON_BOTH = 2'd3
    } mon_state_t;
endpackage

// File: rtl/amon_select.sv
module amon_select #(
    parameter int N_IN  = 68,
    parameter int SEL_W = 7
) (
    input  logic [N_IN-1:0]  data_in,
    input  logic [SEL_W-1:0] sel,
    output logic             watched,
    output logic             sel_off
);
    // Codes at or above N_IN name no input: the watched line is held at 0.
    always_comb begin
        watched = 1'b0;
        sel_off = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == SEL_W'(i)) begin
                watched = data_in[i];
                sel_off = 1'b0;
            end
        end
    end
endmodule

// File: rtl/amon_sync_edge.sv
module amon_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev_q;
    assign fall = ~chain[LAST] & prev_q;
endmodule

// File: rtl/activity_monitor.sv
module activity_monitor
    import amon_pkg::*;
#(
    parameter int N_IN        = 68,
    parameter int SEL_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mon_clk,
    input  logic [SEL_W-1:0] mon_sel,
    input  logic [N_IN-1:0]  data_in,
    output logic             activity
);
    logic       watched, sel_off;
    logic       rise, fall;
    logic       bnd, bnd_fall;
    mon_state_t state_q, state_d, base;
    logic       act_q, act_d;

    amon_select #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
        .data_in (data_in),
        .sel     (mon_sel),
        .watched (watched),
        .sel_off (sel_off)
    );

    amon_sync_edge #(.STAGES(SYNC_STAGES)) u_data_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (watched),
        .rise (rise),
        .fall (fall)
    );

    amon_sync_edge #(.STAGES(SYNC_STAGES)) u_win_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (mon_clk),
        .rise (bnd),
        .fall (bnd_fall)
    );

    // Next-state logic: a boundary restarts from MON_WAIT, then the edge of
    // the same cycle is applied to the new window.
    always_comb begin
        base    = bnd ? MON_WAIT : state_q;
        state_d = base;
        unique case (base)
            MON_WAIT: begin
                if (rise)      state_d = MON_RISE;
                else if (fall) state_d = MON_FALL;
            end
            MON_RISE: if (fall) state_d = MON_BOTH;
            MON_FALL: if (rise) state_d = MON_BOTH;
            MON_BOTH: state_d = MON_BOTH;
        endcase
        act_d = bnd ? (state_q == MON_BOTH) : act_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MON_WAIT;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    // Output process
    always_comb begin
        activity = act_q;
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(activity));

    p_late_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(activity) |-> $past(bnd));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        bnd && !rise && !fall |=> state_q == MON_WAIT);

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == MON_BOTH && !bnd |=> state_q == MON_BOTH);

    p_edge_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}) && $onehot0({bnd, bnd_fall}));

    p_new_window_r4: assert property (@(posedge clk) disable iff (rst)
        bnd && rise |=> state_q == MON_RISE);

    p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        sel_off && $past(sel_off) && $past(sel_off, 2) && $past(sel_off, 3)
            |-> !rise && !fall);
endmodule

// File: tb/activity_monitor_tb.sv
module activity_monitor_tb;
    localparam int N_IN  = 68;
    localparam int SEL_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mon_clk = 1'b0;
    logic [SEL_W-1:0] mon_sel = '0;
    logic [N_IN-1:0]  data_in = '0;
    logic             activity;

    int total = 0;
    int bad   = 0;

    // model state
    logic [N_IN-1:0]  cur_d = '0;
    logic [SEL_W-1:0] cur_s = '0;
    logic             cur_m = 1'b0;
    logic             m_prev_w = 1'b0;
    logic             m_prev_m = 1'b0;
    logic             m_r = 1'b0;
    logic             m_f = 1'b0;
    string            cur_tag = "R7";
    logic             exp_q[$];
    string            tag_q[$];

    always #10 clk = ~clk;

    activity_monitor #(.N_IN(N_IN), .SEL_W(SEL_W), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .mon_clk  (mon_clk),
        .mon_sel  (mon_sel),
        .data_in  (data_in),
        .activity (activity)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: activity=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Driver step: apply current inputs at a falling edge and update the model.
    task automatic step();
        logic w;
        @(negedge clk);
        w = (cur_s < SEL_W'(N_IN)) ? cur_d[cur_s] : 1'b0;
        if (cur_m && !m_prev_m) begin
            exp_q.push_back(m_r && m_f);
            tag_q.push_back(cur_tag);
            m_r = 1'b0;
            m_f = 1'b0;
        end
        if (w && !m_prev_w) m_r = 1'b1;
        if (!w && m_prev_w) m_f = 1'b1;
        m_prev_w = w;
        m_prev_m = cur_m;
        data_in  = cur_d;
        mon_sel  = cur_s;
        mon_clk  = cur_m;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Close the open window: pulse mon_clk, then let the monitor sample.
    task automatic close_win(input string next_tag);
        cur_m = 1'b1;
        hold(3);
        cur_tag = next_tag;
        cur_m = 1'b0;
        hold(4);
    endtask

    task automatic toggle(input int idx, input int times);
        for (int i = 0; i < times; i++) begin
            cur_d[idx] = ~cur_d[idx];
            hold(2);
        end
    endtask

    // Monitor: compare each reported window against the scoreboard.
    initial begin
        forever begin
            @(posedge mon_clk);
            repeat (3) @(posedge clk);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R1: unexpected report activity=%0b expected=none", activity);
            end else begin
                check(activity, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_s = 7'd5;
        hold(5);
        rst = 1'b0;
        hold(1);
        check(activity, 1'b0, "R7 after reset");

        // R7/R2: first window empty
        close_win("R3 rise+fall");
        // R3 / R5: rise and fall on selected input 5
        toggle(5, 2);
        hold(2);
        close_win("R2 empty after active");
        // R2: nothing happens
        hold(6);
        close_win("R3 rise only");
        // R3: rise only
        toggle(5, 1);
        hold(2);
        close_win("R3 fall only");
        // R3: fall only
        toggle(5, 1);
        hold(2);
        close_win("R3 many toggles");
        toggle(5, 5);
        hold(2);
        // R4: input left high; fall lands in the boundary cycle
        cur_d[5] = 1'b0;
        cur_m = 1'b1;
        cur_tag = "R4 boundary fall to new window";
        step();
        hold(2);
        cur_m = 1'b0;
        hold(4);
        // new window holds the boundary fall; add a rise -> active
        toggle(5, 1);
        hold(2);
        close_win("R4 closing window without boundary edge");
        toggle(5, 1);
        hold(2);
        // R4: rise lands on boundary; closing window had only a fall -> 0
        cur_d[5] = 1'b1;
        cur_m = 1'b1;
        step();
        hold(2);
        cur_tag = "R5 other inputs ignored";
        cur_m = 1'b0;
        hold(4);
        cur_d[5] = 1'b0;
        hold(2);
        close_win("R5 other inputs ignored");
        // R5: toggles on unselected inputs only
        toggle(4, 2);
        toggle(67, 2);
        toggle(0, 2);
        close_win("R5 top input selected");
        cur_s = 7'd67;
        hold(3);
        toggle(67, 2);
        hold(2);
        close_win("R6 disable code");
        // R6: disable code, every input toggles
        cur_s = 7'd127;
        hold(3);
        for (int k = 0; k < 2; k++) begin
            cur_d = ~cur_d;
            hold(2);
        end
        close_win("R6 out of range code");
        cur_s = 7'd68;
        hold(3);
        for (int k = 0; k < 2; k++) begin
            cur_d = ~cur_d;
            hold(2);
        end
        close_win("R3 reactivated");
        cur_s = 7'd2;
        hold(3);
        toggle(2, 2);
        hold(2);
        close_win("R7 tail");
        hold(4);
        check(activity, 1'b1, "R1 holds between boundaries");
        // R7: reset mid-run clears a reported 1
        rst = 1'b1;
        hold(3);
        check(activity, 1'b0, "R7 reset clears activity");
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R1: pending=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule